// File: doc/BRIEF.md
# Packet Frame Buffer State Tracker

This block follows the occupancy of a buffer sized to hold a single packet frame, where the frame may contain the end of one packet and the start of the next at once. It can be placed either at a router input or in a shared central queue slot. Flits are written in with head and tail markers and read out from the front. A small internal FIFO stores them. A six-state machine records whether the frame is empty, holds a partly received packet, holds a complete packet, is forwarding a packet whose head has already left, is draining the remainder of a packet, or holds a draining packet together with the start of a following one.

Every flit read out returns one credit upstream on the next cycle. When the last flit of the older packet leaves a shared frame, the block pulses a re-route request so that the new front packet gets a fresh route computation. Any enqueue that breaks the packet protocol is dropped and raises a sticky error flag. An age counter measures the cycles since the most recent accepted head flit.

Top module: `pkt_frame_tracker`

## Requirements
- R1: After a synchronous reset, `state_o` is empty (0), `front_valid`, `reroute_req`, `credit_ret` and `proto_err` are 0. The 3-bit state encoding is empty=0, filling=1, full=2, cut_through=3, leaving=4, shared=5.
- R2: Legal enqueues update the state as follows. In empty, a head+tail flit gives full and a head-only flit gives filling. In filling, a tail gives full and a body flit keeps filling. In cut_through, a tail gives leaving and a body keeps cut_through. In leaving, a head-only flit gives shared. In shared, a body flit keeps shared.
- R3: These enqueues are illegal: a non-head flit in empty; a head in filling or cut_through; any flit in full; a tail or body flit in leaving, or a head+tail flit in leaving; a head or tail flit in shared. An illegal enqueue sets `proto_err`, leaves the state unchanged and is not stored.
- R4: `proto_err` stays 1 through any later traffic until reset.
- R5: Reading a head flit moves filling to cut_through and full to leaving. Reading a tail flit moves leaving to empty and shared to filling. A single-flit packet read from full gives empty. Body reads do not change the state. The empty state implies no stored flits.
- R6: A read happens on a clock edge where `deq_req` and `front_valid` are both 1. `credit_ret` is 1 for exactly the cycle after each read, so the credit count equals the number of flits read.
- R7: A tail read in shared causes `reroute_req` to be 1 for the following cycle. In that cycle the front presents the next packet's head flit.
- R8: When an enqueue and a read share one edge, the read transition is applied first and the enqueue is judged against the result.
- R9: An enqueue while the FIFO holds DEPTH flits and no read occurs on the same edge is illegal as in R3. With a read on the same edge it is accepted.
- R10: `age_o` becomes 0 on the edge of an accepted head enqueue, otherwise it increments each cycle and saturates at its maximum. A rejected head does not clear it.
- R11: Flits leave in arrival order, with their data and markers intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Flit offered for enqueue |
| enq_head | input | 1 | Offered flit starts a packet |
| enq_tail | input | 1 | Offered flit ends a packet |
| enq_data | input | DATA_W | Offered flit payload |
| deq_req | input | 1 | Request to read the front flit |
| front_valid | output | 1 | A flit is stored |
| front_head | output | 1 | Head marker of the front flit |
| front_tail | output | 1 | Tail marker of the front flit |
| front_data | output | DATA_W | Payload of the front flit |
| state_o | output | 3 | Frame state (encoding in R1) |
| reroute_req | output | 1 | Pulse: new front packet needs routing |
| credit_ret | output | 1 | Pulse: one credit returned upstream |
| proto_err | output | 1 | Sticky protocol error |
| age_o | output | AGE_W | Cycles since last accepted head |

## Verification
The assertions assume that a read is requested only as `deq_req` and take the read from the front. They also assume that a flit reaching the front in shared is never a head of the draining packet, which holds because shared can only be entered with the older packet's head already gone. The stimulus builds every state only through legal sequences from reset. It then applies one probe enqueue of each marker combination in each state, resetting between probes, and drains the frame to count credits. Directed sequences cover same-edge read and write, a full FIFO, the shared-to-filling hand-over, and age saturation.

// File: rtl/pft_pkg.sv
package pft_pkg;
  typedef enum logic [2:0] {
    ST_EMPTY  = 3'd0,
    ST_FILL   = 3'd1,
    ST_FULL   = 3'd2,
    ST_CUT    = 3'd3,
    ST_LEAVE  = 3'd4,
    ST_SHARED = 3'd5
  } frame_st_e;
endpackage

// File: rtl/pft_fifo.sv
module pft_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         not_empty,
  output logic         is_full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data   = mem[rd_ptr];
  assign not_empty = (count != '0);
  assign is_full   = (count == CNT_W'(DEPTH));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && is_full && !rd_en));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> not_empty);
endmodule

// File: rtl/pft_ctrl.sv
module pft_ctrl
  import pft_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enq_valid,
  input  logic      enq_head,
  input  logic      enq_tail,
  input  logic      deq_fire,
  input  logic      deq_head,
  input  logic      deq_tail,
  input  logic      store_full,
  input  logic      store_nonempty,
  output logic      enq_accept,
  output frame_st_e state_o,
  output logic      err_o,
  output logic      reroute_o
);
  frame_st_e state_q, mid_st, nxt_st;
  logic      err_q, reroute_q, reroute_n, legal;

  always_comb begin
    mid_st    = state_q;
    reroute_n = 1'b0;
    if (deq_fire) begin
      if (deq_head) begin
        if (mid_st == ST_FILL)      mid_st = ST_CUT;
        else if (mid_st == ST_FULL) mid_st = ST_LEAVE;
      end
      if (deq_tail) begin
        if (mid_st == ST_LEAVE) mid_st = ST_EMPTY;
        else if (mid_st == ST_SHARED) begin
          mid_st    = ST_FILL;
          reroute_n = 1'b1;
        end
      end
    end
  end

  always_comb begin
    legal  = 1'b0;
    nxt_st = mid_st;
    unique case (mid_st)
      ST_EMPTY:  if (enq_head) begin legal = 1'b1; nxt_st = enq_tail ? ST_FULL : ST_FILL; end
      ST_FILL:   if (!enq_head) begin legal = 1'b1; nxt_st = enq_tail ? ST_FULL : ST_FILL; end
      ST_CUT:    if (!enq_head) begin legal = 1'b1; nxt_st = enq_tail ? ST_LEAVE : ST_CUT; end
      ST_LEAVE:  if (enq_head && !enq_tail) begin legal = 1'b1; nxt_st = ST_SHARED; end
      ST_SHARED: if (!enq_head && !enq_tail) legal = 1'b1;
      default:   legal = 1'b0;
    endcase
    if (store_full && !deq_fire) legal = 1'b0;
    if (!enq_valid) begin
      legal  = 1'b0;
      nxt_st = mid_st;
    end else if (!legal) begin
      nxt_st = mid_st;
    end
  end

  assign enq_accept = legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_EMPTY;
      err_q     <= 1'b0;
      reroute_q <= 1'b0;
    end else begin
      state_q   <= nxt_st;
      err_q     <= err_q | (enq_valid & ~legal);
      reroute_q <= reroute_n;
    end
  end

  assign state_o   = state_q;
  assign err_o     = err_q;
  assign reroute_o = reroute_q;

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R5
  empty_means_drained_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EMPTY) |-> !store_nonempty);
  // R7
  reroute_after_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHARED && deq_fire && deq_tail) |=> reroute_q);
  // R3
  full_rejects_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FULL && !deq_fire && enq_valid) |=> err_q);
endmodule

// File: rtl/pft_age.sv
module pft_age #(
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_acc,
  output logic [AGE_W-1:0] age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || head_acc)       age_o <= '0;
    else if (age_o != AGE_MAX) age_o <= age_o + 1'b1;
  end

  // R10
  age_restart_chk: assert property (@(posedge clk) disable iff (rst)
    head_acc |=> (age_o == '0));
endmodule

// File: rtl/pkt_frame_tracker.sv
module pkt_frame_tracker
  import pft_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  parameter int AGE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_valid,
  input  logic              enq_head,
  input  logic              enq_tail,
  input  logic [DATA_W-1:0] enq_data,
  input  logic              deq_req,
  output logic              front_valid,
  output logic              front_head,
  output logic              front_tail,
  output logic [DATA_W-1:0] front_data,
  output logic [2:0]        state_o,
  output logic              reroute_req,
  output logic              credit_ret,
  output logic              proto_err,
  output logic [AGE_W-1:0]  age_o
);
  localparam int FW = DATA_W + 2;

  logic          deq_fire, enq_accept, store_full;
  logic [FW-1:0] rd_word;
  frame_st_e     st;

  assign deq_fire = deq_req & front_valid;

  pft_fifo #(.DEPTH(DEPTH), .W(FW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (enq_accept),
    .wr_data   ({enq_head, enq_tail, enq_data}),
    .rd_en     (deq_fire),
    .rd_data   (rd_word),
    .not_empty (front_valid),
    .is_full   (store_full)
  );

  assign front_head = rd_word[FW-1];
  assign front_tail = rd_word[FW-2];
  assign front_data = rd_word[DATA_W-1:0];

  pft_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .enq_valid      (enq_valid),
    .enq_head       (enq_head),
    .enq_tail       (enq_tail),
    .deq_fire       (deq_fire),
    .deq_head       (front_head),
    .deq_tail       (front_tail),
    .store_full     (store_full),
    .store_nonempty (front_valid),
    .enq_accept     (enq_accept),
    .state_o        (st),
    .err_o          (proto_err),
    .reroute_o      (reroute_req)
  );

  assign state_o = st;

  pft_age #(.AGE_W(AGE_W)) u_age (
    .clk      (clk),
    .rst      (rst),
    .head_acc (enq_accept & enq_head),
    .age_o    (age_o)
  );

  always_ff @(posedge clk) begin
    if (rst) credit_ret <= 1'b0;
    else     credit_ret <= deq_fire;
  end

  // R6
  credit_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    deq_fire |=> credit_ret);
  // R6
  credit_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    !deq_fire |=> !credit_ret);
endmodule

// File: tb/test_pkt_frame_tracker.sv
module test_pkt_frame_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4, DATA_W = 8, AGE_W = 8;

  logic clk = 0, rst = 1;
  logic enq_valid = 0, enq_head = 0, enq_tail = 0, deq_req = 0;
  logic [DATA_W-1:0] enq_data = '0;
  logic front_valid, front_head, front_tail, reroute_req, credit_ret, proto_err;
  logic [DATA_W-1:0] front_data;
  logic [2:0] state_o;
  logic [AGE_W-1:0] age_o;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_frame_tracker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AGE_W(AGE_W)) i_pkt_frame_tracker (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_head(enq_head), .enq_tail(enq_tail),
    .enq_data(enq_data), .deq_req(deq_req), .front_valid(front_valid), .front_head(front_head),
    .front_tail(front_tail), .front_data(front_data), .state_o(state_o),
    .reroute_req(reroute_req), .credit_ret(credit_ret), .proto_err(proto_err), .age_o(age_o));

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic h, input logic t, input int d, input logic dq);
    enq_valid = v; enq_head = h; enq_tail = t; enq_data = DATA_W'(d); deq_req = dq;
    @(posedge clk); @(negedge clk);
    enq_valid = 0; enq_head = 0; enq_tail = 0; deq_req = 0;
  endtask

  task automatic do_reset();
    rst = 1; enq_valid = 0; deq_req = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 0;
  endtask

  // legal paths from reset into each state
  task automatic goto_state(input int s);
    case (s)
      1: step(1, 1, 0, 1, 0);
      2: step(1, 1, 1, 1, 0);
      3: begin step(1, 1, 0, 1, 0); step(0, 0, 0, 0, 1); end
      4: begin step(1, 1, 0, 1, 0); step(1, 0, 1, 2, 0); step(0, 0, 0, 0, 1); end
      5: begin step(1, 1, 0, 1, 0); step(1, 0, 1, 2, 0); step(0, 0, 0, 0, 1); step(1, 1, 0, 3, 0); end
      default: ;
    endcase
  endtask

  // expected {next_state, ok} from the requirement table (R2/R3)
  function automatic int model(input int s, input bit h, input bit t);
    case (s)
      0: return h ? ((t ? 2 : 1) * 2 + 1) : s * 2;
      1: return !h ? ((t ? 2 : 1) * 2 + 1) : s * 2;
      3: return !h ? ((t ? 4 : 3) * 2 + 1) : s * 2;
      4: return (h && !t) ? 11 : s * 2;
      5: return (!h && !t) ? 11 : s * 2;
      default: return s * 2;
    endcase
  endfunction

  function automatic int stored_in(input int s);
    case (s)
      1, 2, 4: return 1;
      5: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic drain(output int credits);
    credits = 0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      deq_req = front_valid;
      @(posedge clk); @(negedge clk);
      deq_req = 0;
      if (credit_ret) credits++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cr, m;
    @(negedge clk);
    do_reset();
    // R1
    chk("R1 state", state_o, 0);
    chk("R1 front_valid", front_valid, 0);
    chk("R1 err", proto_err, 0);
    chk("R1 credit", credit_ret, 0);
    chk("R1 reroute", reroute_req, 0);

    // R2 / R3 sweep over all states and marker combinations
    for (int s = 0; s < 6; s++) begin
      for (int f = 0; f < 4; f++) begin
        do_reset();
        goto_state(s);
        chk("R2 setup state", state_o, s);
        m = model(s, f[1], f[0]);
        step(1, f[1], f[0], 9, 0);
        chk((m % 2) ? "R2 next state" : "R3 state held", state_o, m / 2);
        chk("R3 err flag", proto_err, (m % 2) ? 0 : 1);
        drain(cr);
        chk("R6 R3 credits after drain", cr, stored_in(s) + (m % 2));
      end
    end

    // R5 R7 R11: shared hand-over with data order
    do_reset();
    step(1, 1, 0, 8'h11, 0); step(1, 0, 1, 8'h12, 0);
    step(0, 0, 0, 0, 1);
    chk("R5 full->leaving by head read", state_o, 4);
    step(1, 1, 0, 8'h21, 0); step(1, 0, 0, 8'h22, 0);
    chk("R2 shared body", state_o, 5);
    chk("R11 front is old tail", front_data, 8'h12);
    step(0, 0, 0, 0, 1);
    chk("R5 shared->filling", state_o, 1);
    chk("R7 reroute pulse", reroute_req, 1);
    chk("R7 front is new head", front_head, 1);
    chk("R11 new head data", front_data, 8'h21);
    step(0, 0, 0, 0, 1);
    chk("R7 reroute single cycle", reroute_req, 0);
    chk("R5 filling->cut_through", state_o, 3);
    step(0, 0, 0, 0, 1);
    chk("R5 body read keeps state", state_o, 3);
    chk("R11 drained", front_valid, 0);
    step(1, 0, 1, 8'h23, 0);
    chk("R2 cut_through->leaving", state_o, 4);
    step(0, 0, 0, 0, 1);
    chk("R5 leaving->empty", state_o, 0);
    chk("R4 no error seen", proto_err, 0);

    // R5 single flit packet read from full
    do_reset();
    step(1, 1, 1, 5, 0); step(0, 0, 0, 0, 1);
    chk("R5 single flit full->empty", state_o, 0);

    // R8 same-edge read and enqueue
    do_reset();
    goto_state(4);
    step(1, 1, 0, 7, 1);
    chk("R8 leaving read tail then head", state_o, 1);
    chk("R8 no error", proto_err, 0);
    do_reset();
    goto_state(2);
    step(1, 1, 0, 7, 1);
    chk("R8 full read single then head", state_o, 1);
    chk("R8 no error 2", proto_err, 0);

    // R9 storage limit
    do_reset();
    step(1, 1, 0, 1, 0);
    for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, 2, 0);
    step(1, 0, 0, 3, 1);
    chk("R9 full store with read accepts", proto_err, 0);
    step(1, 0, 0, 4, 0);
    chk("R9 full store rejects", proto_err, 1);
    chk("R9 state held", state_o, 3);
    // R4 sticky through legal traffic
    step(1, 0, 1, 5, 1); step(0, 0, 0, 0, 1);
    chk("R4 err stays", proto_err, 1);
    do_reset();
    chk("R4 reset clears err", proto_err, 0);

    // R10 age
    do_reset();
    step(1, 1, 0, 1, 0);
    chk("R10 age cleared", age_o, 0);
    for (int i = 0; i < 5; i++) begin @(posedge clk); @(negedge clk); end
    chk("R10 age counts", age_o, 5);
    step(1, 1, 0, 1, 0);
    chk("R10 rejected head no clear", age_o, 6);
    for (int i = 0; i < 300; i++) begin @(posedge clk); @(negedge clk); end
    chk("R10 age saturates", age_o, 255);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule